// File: doc/BRIEF.md
# Rotated Framebuffer Descriptor Calculator

This block sits beside a display-refresh DMA engine and turns a description of a framebuffer into the six numbers that engine needs to walk it: the first and last byte addresses it touches, how many elements make up one frame line, how many lines there are, and two signed strides. The element stride moves from one pixel to the next within a line, and the frame stride moves from the last pixel of one line to the first of the next. All four quarter-turn rotations are handled, each with and without a horizontal mirror. A virtual line width larger than the visible width and integer pixel replication factors in x and y are also handled.

Software drives the configuration inputs, pulses `start`, and reads the outputs once `done` pulses. A configuration that cannot be walked sets `error` together with `done` and leaves every descriptor output at its old value. The calculation takes a few cycles because one multiplier is shared across the three products it needs.

Top module: `fbdesc_calc`

## Requirements
- R1: `pixType` selects the bytes per pixel: code 0 gives 1 byte, code 1 gives 2 bytes and code 2 gives 4 bytes. Code 3 is rejected with `error`.
- R2: A `virtWidth` of 0 means the line pitch equals `width`. A `scaleX` or `scaleY` of 0 acts as a factor of 1.
- R3: A nonzero `virtWidth` below `width` is rejected with `error`.
- R4: With pixel address A(x,y) = base + (y·pitch·scaleY + x·scaleX)·bytes, `topAddr` and `bottomAddr` are the addresses of the corner pixels that the rotation (`rotAngle` in degrees) and `mirror` select, as listed in the table below.
- R5: A step from pixel S to pixel D is encoded as A(D) − A(S) − bytes + 1, in 32-bit two's complement. `elemIndex` is the element step and `frameIndex` is the frame step of the selected walk. Without rotation, mirror, virtual width or scaling, `elemIndex` is 1.
- R6: At 0° and 180°, `elemCount` = `width` and `frameCount` = `height`. At 90° and 270° the two counts are swapped.
- R7: When `compatPad` is set, 4-byte pixels are selected, the angle is 0° and there is no mirror, `bottomAddr` is 2 more than the last pixel address. In every other case `compatPad` has no effect.
- R8: `dualIndex` is 1 exactly when the angle, `mirror`, `virtWidth`, `scaleX` or `scaleY` is nonzero.
- R9: A `rotAngle` other than 0, 90, 180 or 270 is rejected with `error`. Any rejection pulses `done` in the cycle after `start` and leaves all descriptor outputs unchanged.
- R10: An accepted calculation ends with exactly one single-cycle `done` pulse with `error` low. A `start` that arrives while a calculation is running is ignored.
- R11: After reset, `done` and `error` are 0 and all descriptor outputs are 0.

Walk table (x/y: 0, 1, or far = w−1 / h−1):

| Angle | Mirror | Top | Bottom | Element step | Frame step |
|---|---|---|---|---|---|
| 0 | no | (0,0) | (w−1,h−1) | (0,0)→(1,0) | (w−1,0)→(0,1) |
| 0 | yes | (w−1,0) | (0,h−1) | (1,0)→(0,0) | (0,0)→(w−1,1) |
| 90 | no | (0,h−1) | (w−1,0) | (0,1)→(0,0) | (0,0)→(1,h−1) |
| 90 | yes | (w−1,h−1) | (0,0) | (0,1)→(0,0) | (1,0)→(0,h−1) |
| 180 | no | (w−1,h−1) | (0,0) | (1,0)→(0,0) | (0,1)→(w−1,0) |
| 180 | yes | (0,h−1) | (w−1,0) | (0,0)→(1,0) | (w−1,1)→(0,0) |
| 270 | no | (w−1,0) | (0,h−1) | (0,0)→(0,1) | (1,h−1)→(0,0) |
| 270 | yes | (0,0) | (w−1,h−1) | (0,0)→(0,1) | (0,h−1)→(1,0) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch a calculation |
| baseAddr | input | 32 | Byte address of pixel (0,0) |
| width | input | 16 | Visible width in pixels |
| height | input | 16 | Visible height in pixels |
| virtWidth | input | 16 | Line pitch in pixels, 0 = width |
| scaleX | input | 8 | Horizontal replication factor, 0 = 1 |
| scaleY | input | 8 | Vertical replication factor, 0 = 1 |
| pixType | input | 2 | Pixel size code |
| rotAngle | input | 9 | Rotation in degrees |
| mirror | input | 1 | Horizontal mirror |
| compatPad | input | 1 | Legacy bottom padding mode |
| done | output | 1 | Calculation finished (one cycle) |
| error | output | 1 | Last request was rejected |
| topAddr | output | 32 | First address of the walk |
| bottomAddr | output | 32 | Last address of the walk |
| elemCount | output | 16 | Elements per frame line |
| frameCount | output | 16 | Frame lines |
| elemIndex | output | 32 | Signed element stride |
| frameIndex | output | 32 | Signed frame stride |
| dualIndex | output | 1 | Strided addressing needed |

## Verification
The bench runs every angle with and without mirror against a model that evaluates the pixel address formula on the corner coordinates. A design that swaps a corner or a step endpoint therefore shows a wrong address or stride, and a design that forgets the element-size correction shows a stride off by the pixel size. Default values are compared with the same configuration written out explicitly, which exposes a design that multiplies by a zero scale or pitch. Rejections are checked for unchanged outputs, and the legacy padding is checked both where it applies and at a rotated angle where it must not. A second `start` issued mid-calculation must neither alter the result nor produce a second `done`.

// File: rtl/fbdesc_pkg.sv
package fbdesc_pkg;

  // control strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic capPitch;
    logic capYFar;
    logic capXFar;
    logic commit;
  } strobe_t;

  // coordinate code: 0 = origin, 1 = one step, 2 = far edge
  typedef struct packed {
    logic [1:0] xc;
    logic [1:0] yc;
  } pt_t;

  typedef struct packed {
    pt_t top;
    pt_t bot;
    pt_t eSrc;
    pt_t eDst;
    pt_t fSrc;
    pt_t fDst;
  } walk_t;

  localparam logic [1:0] C0 = 2'd0;
  localparam logic [1:0] C1 = 2'd1;
  localparam logic [1:0] CF = 2'd2;

  function automatic pt_t mk(logic [1:0] x, logic [1:0] y);
    pt_t p;
    p.xc = x;
    p.yc = y;
    return p;
  endfunction

  // rot: 0=0deg 1=90 2=180 3=270
  function automatic walk_t walkFor(logic [1:0] rot, logic mir);
    walk_t w;
    case ({rot, mir})
      3'b000: w = {mk(C0,C0), mk(CF,CF), mk(C0,C0), mk(C1,C0), mk(CF,C0), mk(C0,C1)};
      3'b001: w = {mk(CF,C0), mk(C0,CF), mk(C1,C0), mk(C0,C0), mk(C0,C0), mk(CF,C1)};
      3'b010: w = {mk(C0,CF), mk(CF,C0), mk(C0,C1), mk(C0,C0), mk(C0,C0), mk(C1,CF)};
      3'b011: w = {mk(CF,CF), mk(C0,C0), mk(C0,C1), mk(C0,C0), mk(C1,C0), mk(C0,CF)};
      3'b100: w = {mk(CF,CF), mk(C0,C0), mk(C1,C0), mk(C0,C0), mk(C0,C1), mk(CF,C0)};
      3'b101: w = {mk(C0,CF), mk(CF,C0), mk(C0,C0), mk(C1,C0), mk(CF,C1), mk(C0,C0)};
      3'b110: w = {mk(CF,C0), mk(C0,CF), mk(C0,C0), mk(C0,C1), mk(C1,CF), mk(C0,C0)};
      default: w = {mk(C0,C0), mk(CF,CF), mk(C0,C0), mk(C0,C1), mk(C0,CF), mk(C1,C0)};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fbdesc_ctrl.sv
module fbdesc_ctrl
  import fbdesc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    cfgBad,
  output strobe_t stb,
  output logic    done,
  output logic    error
);

  typedef enum logic [2:0] {IDLE, MUL_PITCH, MUL_YFAR, MUL_XFAR, FINISH} state_t;
  state_t state;

  always_comb begin
    stb = '0;
    case (state)
      IDLE:      stb.load     = start && !cfgBad;
      MUL_PITCH: stb.capPitch = 1'b1;
      MUL_YFAR:  stb.capYFar  = 1'b1;
      MUL_XFAR:  stb.capXFar  = 1'b1;
      FINISH:    stb.commit   = 1'b1;
      default:   stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          if (cfgBad) begin
            done  <= 1'b1;
            error <= 1'b1;
          end else begin
            state <= MUL_PITCH;
          end
        end
        MUL_PITCH: state <= MUL_YFAR;
        MUL_YFAR:  state <= MUL_XFAR;
        MUL_XFAR:  state <= FINISH;
        FINISH: begin
          done  <= 1'b1;
          error <= 1'b0;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fbdesc_dp.sv
module fbdesc_dp
  import fbdesc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       stb,
  input  logic [AW-1:0] baseAddr,
  input  logic [DW-1:0] width,
  input  logic [DW-1:0] height,
  input  logic [DW-1:0] virtWidth,
  input  logic [SW-1:0] scaleX,
  input  logic [SW-1:0] scaleY,
  input  logic [1:0]    pixType,
  input  logic [8:0]    rotAngle,
  input  logic          mirror,
  input  logic          compatPad,
  output logic          cfgBad,
  output logic [AW-1:0] topAddr,
  output logic [AW-1:0] bottomAddr,
  output logic [DW-1:0] elemCount,
  output logic [DW-1:0] frameCount,
  output logic [AW-1:0] elemIndex,
  output logic [AW-1:0] frameIndex,
  output logic          dualIndex
);

  localparam int PW = AW + DW;

  // angle decode
  logic       angOk;
  logic [1:0] rotCode;
  always_comb begin
    angOk   = 1'b1;
    rotCode = 2'd0;
    case (rotAngle)
      9'd0:    rotCode = 2'd0;
      9'd90:   rotCode = 2'd1;
      9'd180:  rotCode = 2'd2;
      9'd270:  rotCode = 2'd3;
      default: angOk   = 1'b0;
    endcase
  end

  logic [DW-1:0] vwIn;
  assign vwIn   = (virtWidth == '0) ? width : virtWidth;
  assign cfgBad = (pixType == 2'd3) || !angOk || (vwIn < width);

  // latched configuration
  logic [AW-1:0] cBase;
  logic [DW-1:0] cW, cH, cVw;
  logic [SW-1:0] cXs, cYs;
  logic [1:0]    cShift, cRot;
  logic          cMir, cPad, cDual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cBase <= '0; cW <= '0; cH <= '0; cVw <= '0;
      cXs <= '0; cYs <= '0; cShift <= '0; cRot <= '0;
      cMir <= 1'b0; cPad <= 1'b0; cDual <= 1'b0;
    end else if (stb.load) begin
      cBase  <= baseAddr;
      cW     <= width;
      cH     <= height;
      cVw    <= vwIn;
      cXs    <= (scaleX == '0) ? SW'(1) : scaleX;
      cYs    <= (scaleY == '0) ? SW'(1) : scaleY;
      cShift <= pixType;
      cRot   <= rotCode;
      cMir   <= mirror;
      cPad   <= compatPad;
      cDual  <= (rotAngle != '0) || mirror || (virtWidth != '0)
                || (scaleX != '0) || (scaleY != '0);
    end
  end

  // shared multiplier
  logic [AW-1:0] rowPitch, yFar, xFar;
  logic [AW-1:0] mulA;
  logic [DW-1:0] mulB;
  logic [PW-1:0] prod;

  always_comb begin
    mulA = AW'(cXs);
    mulB = cW - DW'(1);
    if (stb.capPitch) begin
      mulA = AW'(cVw);
      mulB = DW'(cYs);
    end else if (stb.capYFar) begin
      mulA = rowPitch;
      mulB = cH - DW'(1);
    end
  end
  assign prod = PW'(mulA) * PW'(mulB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowPitch <= '0; yFar <= '0; xFar <= '0;
    end else begin
      if (stb.capPitch) rowPitch <= prod[AW-1:0];
      if (stb.capYFar)  yFar     <= prod[AW-1:0];
      if (stb.capXFar)  xFar     <= prod[AW-1:0];
    end
  end

  // corner offsets in pixel units
  function automatic logic [AW-1:0] offOf(pt_t p, logic [AW-1:0] xs,
      logic [AW-1:0] xf, logic [AW-1:0] rp, logic [AW-1:0] yf);
    logic [AW-1:0] xv, yv;
    xv = (p.xc == C1) ? xs : (p.xc == CF) ? xf : '0;
    yv = (p.yc == C1) ? rp : (p.yc == CF) ? yf : '0;
    return xv + yv;
  endfunction

  walk_t         walk;
  logic [AW-1:0] xsW, esz;
  logic [AW-1:0] oTop, oBot, oES, oED, oFS, oFD;
  logic [AW-1:0] nTop, nBot, nEI, nFI;
  logic          padHit;

  assign walk = walkFor(cRot, cMir);
  assign xsW  = AW'(cXs);
  assign esz  = AW'(1) << cShift;
  assign oTop = offOf(walk.top,  xsW, xFar, rowPitch, yFar);
  assign oBot = offOf(walk.bot,  xsW, xFar, rowPitch, yFar);
  assign oES  = offOf(walk.eSrc, xsW, xFar, rowPitch, yFar);
  assign oED  = offOf(walk.eDst, xsW, xFar, rowPitch, yFar);
  assign oFS  = offOf(walk.fSrc, xsW, xFar, rowPitch, yFar);
  assign oFD  = offOf(walk.fDst, xsW, xFar, rowPitch, yFar);

  assign padHit = cPad && (cShift == 2'd2) && (cRot == 2'd0) && !cMir;
  assign nTop = cBase + (oTop << cShift);
  assign nBot = cBase + (oBot << cShift) + (padHit ? AW'(2) : '0);
  assign nEI  = ((oED - oES) << cShift) - esz + AW'(1);
  assign nFI  = ((oFD - oFS) << cShift) - esz + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topAddr <= '0; bottomAddr <= '0; elemCount <= '0; frameCount <= '0;
      elemIndex <= '0; frameIndex <= '0; dualIndex <= 1'b0;
    end else if (stb.commit) begin
      topAddr    <= nTop;
      bottomAddr <= nBot;
      elemCount  <= cRot[0] ? cH : cW;
      frameCount <= cRot[0] ? cW : cH;
      elemIndex  <= nEI;
      frameIndex <= nFI;
      dualIndex  <= cDual;
    end
  end

endmodule

// File: rtl/fbdesc_calc.sv
module fbdesc_calc
  import fbdesc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] baseAddr,
  input  logic [DW-1:0] width,
  input  logic [DW-1:0] height,
  input  logic [DW-1:0] virtWidth,
  input  logic [SW-1:0] scaleX,
  input  logic [SW-1:0] scaleY,
  input  logic [1:0]    pixType,
  input  logic [8:0]    rotAngle,
  input  logic          mirror,
  input  logic          compatPad,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] topAddr,
  output logic [AW-1:0] bottomAddr,
  output logic [DW-1:0] elemCount,
  output logic [DW-1:0] frameCount,
  output logic [AW-1:0] elemIndex,
  output logic [AW-1:0] frameIndex,
  output logic          dualIndex
);

  strobe_t stb;
  logic    cfgBad;

  fbdesc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfgBad(cfgBad),
    .stb(stb), .done(done), .error(error)
  );

  fbdesc_dp #(.AW(AW), .DW(DW), .SW(SW)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .baseAddr(baseAddr), .width(width), .height(height),
    .virtWidth(virtWidth), .scaleX(scaleX), .scaleY(scaleY),
    .pixType(pixType), .rotAngle(rotAngle), .mirror(mirror),
    .compatPad(compatPad), .cfgBad(cfgBad),
    .topAddr(topAddr), .bottomAddr(bottomAddr),
    .elemCount(elemCount), .frameCount(frameCount),
    .elemIndex(elemIndex), .frameIndex(frameIndex),
    .dualIndex(dualIndex)
  );

endmodule

// File: rtl/fbdesc_calc_chk.sv
module fbdesc_calc_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          error,
  input logic [AW-1:0] topAddr,
  input logic [AW-1:0] bottomAddr,
  input logic [AW-1:0] elemIndex,
  input logic          dualIndex
);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  // R9
  reject_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> ($stable(topAddr) && $stable(bottomAddr)));

  // R10
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(topAddr) && $stable(elemIndex)));

  // R5
  plain_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error && !dualIndex) |-> (elemIndex == AW'(1)));

endmodule

bind fbdesc_calc fbdesc_calc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .error(error),
  .topAddr(topAddr), .bottomAddr(bottomAddr),
  .elemIndex(elemIndex), .dualIndex(dualIndex)
);

// File: tb/fbdesc_calc_test.sv
module fbdesc_calc_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [15:0] width = '0, height = '0, virtWidth = '0;
  logic [7:0]  scaleX = '0, scaleY = '0;
  logic [1:0]  pixType = '0;
  logic [8:0]  rotAngle = '0;
  logic        mirror = 1'b0, compatPad = 1'b0;
  logic        done, error, dualIndex;
  logic [31:0] topAddr, bottomAddr, elemIndex, frameIndex;
  logic [15:0] elemCount, frameCount;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  fbdesc_calc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .baseAddr(baseAddr),
    .width(width), .height(height), .virtWidth(virtWidth),
    .scaleX(scaleX), .scaleY(scaleY), .pixType(pixType),
    .rotAngle(rotAngle), .mirror(mirror), .compatPad(compatPad),
    .done(done), .error(error), .topAddr(topAddr), .bottomAddr(bottomAddr),
    .elemCount(elemCount), .frameCount(frameCount),
    .elemIndex(elemIndex), .frameIndex(frameIndex), .dualIndex(dualIndex)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model state
  longint mBase, mVw, mXs, mYs, mEs;

  function automatic logic [31:0] pa(longint x, longint y);
    longint a;
    a = mBase + (y * mVw * mYs + x * mXs) * mEs;
    return a[31:0];
  endfunction

  function automatic logic [31:0] stp(longint sx, longint sy, longint dx, longint dy);
    return pa(dx, dy) - pa(sx, sy) - 32'(mEs) + 32'd1;
  endfunction

  task automatic setCfg(input logic [31:0] b, input int w, input int h,
      input int vw, input int xs, input int ys, input int dt,
      input int ang, input bit mir, input bit pad);
    baseAddr = b; width = 16'(w); height = 16'(h); virtWidth = 16'(vw);
    scaleX = 8'(xs); scaleY = 8'(ys); pixType = 2'(dt);
    rotAngle = 9'(ang); mirror = mir; compatPad = pad;
  endtask

  task automatic pulseAndWait(output int lat);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // valid calculation, compared with the model
  task automatic runCase(input string req, input logic [31:0] b, input int w,
      input int h, input int vw, input int xs, input int ys, input int dt,
      input int ang, input bit mir, input bit pad);
    int lat;
    longint W, H;
    logic [31:0] eTop, eBot, eEI, eFI;
    logic [15:0] eEC, eFC;
    bit eDual;
    setCfg(b, w, h, vw, xs, ys, dt, ang, mir, pad);
    mBase = b; W = w; H = h;
    mVw = (vw == 0) ? w : vw;
    mXs = (xs == 0) ? 1 : xs;
    mYs = (ys == 0) ? 1 : ys;
    mEs = (dt == 0) ? 1 : (dt == 1) ? 2 : 4;
    case ({ang[8:0], mir})
      {9'd0, 1'b0}:   begin eTop = pa(0,0);     eBot = pa(W-1,H-1); eEI = stp(0,0,1,0); eFI = stp(W-1,0,0,1); end
      {9'd0, 1'b1}:   begin eTop = pa(W-1,0);   eBot = pa(0,H-1);   eEI = stp(1,0,0,0); eFI = stp(0,0,W-1,1); end
      {9'd90, 1'b0}:  begin eTop = pa(0,H-1);   eBot = pa(W-1,0);   eEI = stp(0,1,0,0); eFI = stp(0,0,1,H-1); end
      {9'd90, 1'b1}:  begin eTop = pa(W-1,H-1); eBot = pa(0,0);     eEI = stp(0,1,0,0); eFI = stp(1,0,0,H-1); end
      {9'd180, 1'b0}: begin eTop = pa(W-1,H-1); eBot = pa(0,0);     eEI = stp(1,0,0,0); eFI = stp(0,1,W-1,0); end
      {9'd180, 1'b1}: begin eTop = pa(0,H-1);   eBot = pa(W-1,0);   eEI = stp(0,0,1,0); eFI = stp(W-1,1,0,0); end
      {9'd270, 1'b0}: begin eTop = pa(W-1,0);   eBot = pa(0,H-1);   eEI = stp(0,0,0,1); eFI = stp(1,H-1,0,0); end
      default:        begin eTop = pa(0,0);     eBot = pa(W-1,H-1); eEI = stp(0,0,0,1); eFI = stp(0,H-1,1,0); end
    endcase
    if (pad && dt == 2 && ang == 0 && !mir) eBot = eBot + 32'd2;
    eEC = (ang == 90 || ang == 270) ? 16'(h) : 16'(w);
    eFC = (ang == 90 || ang == 270) ? 16'(w) : 16'(h);
    eDual = (ang != 0) || mir || (vw != 0) || (xs != 0) || (ys != 0);
    pulseAndWait(lat);
    chk({req, " R10"}, "done", 32'(done), 32'd1);
    chk({req, " R10"}, "error", 32'(error), 32'd0);
    chk({req, " R4"}, "topAddr", topAddr, eTop);
    chk({req, " R4/R7"}, "bottomAddr", bottomAddr, eBot);
    chk({req, " R5"}, "elemIndex", elemIndex, eEI);
    chk({req, " R5"}, "frameIndex", frameIndex, eFI);
    chk({req, " R6"}, "elemCount", 32'(elemCount), 32'(eEC));
    chk({req, " R6"}, "frameCount", 32'(frameCount), 32'(eFC));
    chk({req, " R8"}, "dualIndex", 32'(dualIndex), 32'(eDual));
    @(negedge clk);
    chk({req, " R10"}, "done one cycle", 32'(done), 32'd0);
  endtask

  // rejected configuration: error with done, outputs unchanged
  task automatic runBad(input string req, input logic [31:0] b, input int w,
      input int h, input int vw, input int dt, input int ang);
    int lat;
    logic [31:0] oTop, oBot, oEI, oFI;
    logic [15:0] oEC;
    oTop = topAddr; oBot = bottomAddr; oEI = elemIndex; oFI = frameIndex;
    oEC = elemCount;
    setCfg(b, w, h, vw, 0, 0, dt, ang, 1'b0, 1'b0);
    pulseAndWait(lat);
    chk(req, "done", 32'(done), 32'd1);
    chk(req, "latency", 32'(lat), 32'd1);
    chk(req, "error", 32'(error), 32'd1);
    chk(req, "topAddr kept", topAddr, oTop);
    chk(req, "bottomAddr kept", bottomAddr, oBot);
    chk(req, "elemIndex kept", elemIndex, oEI);
    chk(req, "frameIndex kept", frameIndex, oFI);
    chk(req, "elemCount kept", 32'(elemCount), 32'(oEC));
  endtask

  task automatic testReset();
    chk("R11", "done", 32'(done), 32'd0);
    chk("R11", "error", 32'(error), 32'd0);
    chk("R11", "topAddr", topAddr, 32'd0);
    chk("R11", "bottomAddr", bottomAddr, 32'd0);
    chk("R11", "elemIndex", elemIndex, 32'd0);
    chk("R11", "frameCount", 32'(frameCount), 32'd0);
    chk("R11", "dualIndex", 32'(dualIndex), 32'd0);
  endtask

  task automatic testDefaults();
    logic [31:0] t1, b1, f1;
    runCase("R2 zero", 32'h0002_0000, 10, 6, 0, 0, 0, 1, 90, 1'b0, 1'b0);
    t1 = topAddr; b1 = bottomAddr; f1 = frameIndex;
    runCase("R2 explicit", 32'h0002_0000, 10, 6, 10, 1, 1, 1, 90, 1'b0, 1'b0);
    chk("R2", "top default==explicit", topAddr, t1);
    chk("R2", "bottom default==explicit", bottomAddr, b1);
    chk("R2", "frameIndex default==explicit", frameIndex, f1);
  endtask

  task automatic testBusyIgnore();
    int cnt;
    setCfg(32'h0000_4000, 5, 3, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    setCfg(32'h0FFF_0000, 9, 9, 0, 2, 2, 2, 180, 1'b1, 1'b0);
    @(negedge clk) start = 1'b0;
    cnt = 0;
    while (!done && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
    chk("R10 busy", "done", 32'(done), 32'd1);
    chk("R10 busy", "topAddr from first start", topAddr, 32'h0000_4000);
    chk("R10 busy", "bottomAddr from first start", bottomAddr, 32'h0000_4000 + 32'd14);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk("R10 busy", "extra done pulses", 32'(cnt), 32'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    runCase("R1 R4 rot0", 32'h0000_1000, 8, 4, 0, 0, 0, 1, 0, 1'b0, 1'b0);
    runCase("R1 rot0 mir 8b", 32'h0000_2000, 7, 5, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    runCase("R4 rot90 scaled", 32'h0010_0000, 6, 4, 12, 2, 3, 1, 90, 1'b0, 1'b0);
    runCase("R4 rot90 mir 32b", 32'h0010_0000, 6, 4, 0, 0, 0, 2, 90, 1'b1, 1'b0);
    runCase("R4 rot180", 32'h0003_0000, 16, 9, 20, 0, 0, 1, 180, 1'b0, 1'b0);
    runCase("R4 rot180 mir", 32'h0003_0000, 16, 9, 0, 3, 2, 0, 180, 1'b1, 1'b0);
    runCase("R4 rot270", 32'h8000_0000, 11, 7, 0, 0, 0, 2, 270, 1'b0, 1'b0);
    runCase("R4 rot270 mir", 32'h8000_0000, 11, 7, 13, 1, 2, 1, 270, 1'b1, 1'b0);
    runCase("R7 pad hit", 32'h0000_8000, 4, 3, 0, 0, 0, 2, 0, 1'b0, 1'b1);
    runCase("R7 pad ignored", 32'h0000_8000, 4, 3, 0, 0, 0, 2, 90, 1'b0, 1'b1);
    testDefaults();
    runBad("R1 bad pixType", 32'h1234_0000, 8, 4, 0, 3, 0);
    runBad("R9 bad angle", 32'h1234_0000, 8, 4, 0, 1, 45);
    runBad("R3 narrow virtWidth", 32'h1234_0000, 8, 4, 6, 1, 0);
    runCase("R10 after reject", 32'h0000_0100, 3, 2, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    testBusyIgnore();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule